// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog on a small 16-bit register bus. Once software starts it, a down-counter runs from a programmable reload value toward zero. A divider with a selectable power-of-two ratio clocks the counter. If software does not service it in time, the block raises a one-cycle reset request. Software controls the block only by writing 16-bit magic values to a key register. One value starts the timer, a second refreshes the count, and a third opens the prescaler and reload registers for writing. No key value stops a running timer. Only a system reset stops it.

New prescaler and reload values do not act at once. An accepted write raises a per-register pending flag in the status register. The flag models the transfer into a slower timer domain. When it drops, the new value becomes the one the timer uses. Reads return the stored prescaler and reload values and the pending flags. The key register reads back as zero.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the reads are: prescaler (address 0x4) = 0, reload (address 0x8) = 0xFFF, status (address 0xC) = 0, key (address 0x0) = 0. The reset request output is low.
- R2: While the registers are locked, writes to the prescaler or reload register are ignored. Their readback does not change and no status flag rises. The block is locked after reset.
- R3: Writing 0x5555 to the key register unlocks the prescaler and reload registers. An accepted write is read back as stored: prescaler in bits 2:0, reload in bits 11:0. Any other key value locks them again.
- R4: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1. The bit stays set for exactly 4 cycles after the write edge and then clears.
- R5: Prescaler codes 0 to 6 divide the timer clock by 4 shifted left by the code (4 up to 256). Code 7 also divides by 256.
- R6: Writing 0xCCCC to the key register starts the timer. The first reset request comes exactly (reload + 1) × division cycles after the start edge and lasts one cycle.
- R7: After each reset request the counter reloads and keeps running. The next request follows one full period later, using the reload value in effect at that time.
- R8: Writing 0xAAAA to the key register while running restarts a full period, measured from that write.
- R9: Once started, no key value stops the timer.
- R10: A new prescaler or reload value takes effect only after its pending flag clears. A start issued while a reload write is pending uses the previous value.
- R11: Before the timer is started, no reset request occurs, even after a refresh key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_en |
| bus_addr | input | 4 | Byte address: 0x0 key, 0x4 prescaler, 0x8 reload, 0xC status; must be word aligned |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| wdog_rst_o | output | 1 | One-cycle reset request on timeout |

## Verification
Some properties are checked by assertions on every cycle. The reset request is one cycle wide, and it never rises while the timer is stopped. The running state, once set, never falls. A locked write leaves the stored prescaler unchanged. When a pending flag drops, the active value equals the stored one. After a request the counter holds the reload value it was given. Other behaviour can only be shown by the bench scenarios. These cover the exact timeout period for each divider code and reload value, and refresh restarting the period. A start issued during a pending reload uses the old value. Stray key values neither stop the timer nor unlock it.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
    localparam int BUS_AW = 4;
    localparam int BUS_DW = 16;

    typedef enum logic [1:0] {
        SEL_KEY  = 2'd0,
        SEL_PRE  = 2'd1,
        SEL_RLD  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    localparam logic [BUS_DW-1:0] KEY_OPEN  = 16'h5555;
    localparam logic [BUS_DW-1:0] KEY_GO    = 16'hCCCC;
    localparam logic [BUS_DW-1:0] KEY_KICK  = 16'hAAAA;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import keyed_wdog_pkg::*;
#(
    parameter int RELOAD_W   = 12,
    parameter int CODE_W     = 3,
    parameter int SYNC_CYC   = 4,
    parameter int RELOAD_RST = 4095
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    output logic                 start_o,
    output logic                 kick_o,
    output logic [CODE_W-1:0]    code_o,
    output logic [RELOAD_W-1:0]  reload_o
);
    localparam int SYNC_W = $clog2(SYNC_CYC + 1);

    typedef struct packed {
        logic                unlock;
        logic [CODE_W-1:0]   code_sh;
        logic [RELOAD_W-1:0] rld_sh;
        logic [CODE_W-1:0]   code_act;
        logic [RELOAD_W-1:0] rld_act;
        logic [SYNC_W-1:0]   pend_pre;
        logic [SYNC_W-1:0]   pend_rld;
    } cfg_state_t;

    cfg_state_t q, d;
    reg_sel_e   sel;
    logic       aligned;
    logic       wr;

    always_comb begin
        sel     = reg_sel_e'(bus_addr[3:2]);
        aligned = (bus_addr[1:0] == 2'b00);
        wr      = bus_en && bus_we && aligned;
        d       = q;
        start_o = 1'b0;
        kick_o  = 1'b0;

        if (q.pend_pre != '0) begin
            d.pend_pre = q.pend_pre - 1'b1;
            if (q.pend_pre == SYNC_W'(1)) d.code_act = q.code_sh;
        end
        if (q.pend_rld != '0) begin
            d.pend_rld = q.pend_rld - 1'b1;
            if (q.pend_rld == SYNC_W'(1)) d.rld_act = q.rld_sh;
        end

        if (wr) begin
            case (sel)
                SEL_KEY: begin
                    d.unlock = (bus_wdata == KEY_OPEN);
                    start_o  = (bus_wdata == KEY_GO);
                    kick_o   = (bus_wdata == KEY_KICK);
                end
                SEL_PRE: begin
                    if (q.unlock) begin
                        d.code_sh  = bus_wdata[CODE_W-1:0];
                        d.pend_pre = SYNC_W'(SYNC_CYC);
                    end
                end
                SEL_RLD: begin
                    if (q.unlock) begin
                        d.rld_sh   = bus_wdata[RELOAD_W-1:0];
                        d.pend_rld = SYNC_W'(SYNC_CYC);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (sel)
                SEL_PRE:  bus_rdata[CODE_W-1:0]   = q.code_sh;
                SEL_RLD:  bus_rdata[RELOAD_W-1:0] = q.rld_sh;
                SEL_STAT: bus_rdata[1:0] = {q.pend_rld != '0, q.pend_pre != '0};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign code_o   = q.code_act;
    assign reload_o = q.rld_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.unlock   <= 1'b0;
            q.code_sh  <= '0;
            q.rld_sh   <= RELOAD_W'(RELOAD_RST);
            q.code_act <= '0;
            q.rld_act  <= RELOAD_W'(RELOAD_RST);
            q.pend_pre <= '0;
            q.pend_rld <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: a locked prescaler write leaves the stored code alone
    assert_locked_pre_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == 4'h4 && !q.unlock) |=> $stable(q.code_sh));

    // R10: when a pending flag drops, the active value matches the stored one
    assert_commit_pre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.pend_pre != '0) |-> (q.code_act == q.code_sh));
    assert_commit_rld_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.pend_rld != '0) |-> (q.rld_act == q.rld_sh));

    // R4: the pending window never exceeds its length
    assert_pend_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend_pre <= SYNC_W'(SYNC_CYC)) && (q.pend_rld <= SYNC_W'(SYNC_CYC)));
endmodule

// File: rtl/wdog_prediv.sv
module wdog_prediv #(
    parameter int CODE_W     = 3,
    parameter int MAX_SHIFT  = 6,
    parameter int BASE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              clear_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int PCNT_W = MAX_SHIFT + BASE_SHIFT;

    typedef struct packed {
        logic [PCNT_W-1:0] cnt;
    } div_state_t;

    div_state_t        q, d;
    logic [PCNT_W-1:0] lim;
    int                sh;

    always_comb begin
        sh     = (int'(code_i) > MAX_SHIFT) ? MAX_SHIFT : int'(code_i);
        lim    = PCNT_W'((32'd1 << (sh + BASE_SHIFT)) - 32'd1);
        tick_o = run_i && !clear_i && (q.cnt >= lim);
        d      = q;
        if (clear_i || !run_i || tick_o) d.cnt = '0;
        else                             d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.cnt <= '0;
        else        q <= d;
    end

    // R5: every tick starts a fresh division interval
    assert_tick_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (q.cnt == '0));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int RELOAD_W   = 12,
    parameter int RELOAD_RST = 4095
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                kick_i,
    input  logic                tick_i,
    input  logic [RELOAD_W-1:0] reload_i,
    output logic                running_o,
    output logic                bark_o
);
    typedef struct packed {
        logic                running;
        logic [RELOAD_W-1:0] cnt;
        logic                bark;
    } core_state_t;

    core_state_t q, d;

    always_comb begin
        d      = q;
        d.bark = 1'b0;
        if (start_i) d.running = 1'b1;
        if (start_i || kick_i) begin
            d.cnt = reload_i;
        end else if (q.running && tick_i) begin
            if (q.cnt == '0) begin
                d.bark = 1'b1;
                d.cnt  = reload_i;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    assign running_o = q.running;
    assign bark_o    = q.bark;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.running <= 1'b0;
            q.cnt     <= RELOAD_W'(RELOAD_RST);
            q.bark    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // R6: the reset request is a single-cycle pulse
    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.bark |=> !q.bark);
    // R9: nothing clears the running state
    assert_sticky_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.running |=> q.running);
    // R11: no request while stopped
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !q.running |-> !q.bark);
    // R7: after a request the counter holds the reload value
    assert_reload_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.bark |-> (q.cnt == $past(reload_i)));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int RELOAD_W  = 12,
    parameter int CODE_W    = 3,
    parameter int SYNC_CYC  = 4,
    parameter int MAX_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              wdog_rst_o
);
    localparam int RELOAD_RST = (1 << RELOAD_W) - 1;

    logic                start_w;
    logic                kick_w;
    logic [CODE_W-1:0]   code_w;
    logic [RELOAD_W-1:0] reload_w;
    logic                running_w;
    logic                tick_w;

    wdog_cfg #(
        .RELOAD_W  (RELOAD_W),
        .CODE_W    (CODE_W),
        .SYNC_CYC  (SYNC_CYC),
        .RELOAD_RST(RELOAD_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .start_o  (start_w),
        .kick_o   (kick_w),
        .code_o   (code_w),
        .reload_o (reload_w)
    );

    wdog_prediv #(
        .CODE_W    (CODE_W),
        .MAX_SHIFT (MAX_SHIFT),
        .BASE_SHIFT(2)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running_w),
        .clear_i(start_w || kick_w),
        .code_i (code_w),
        .tick_o (tick_w)
    );

    wdog_core #(
        .RELOAD_W  (RELOAD_W),
        .RELOAD_RST(RELOAD_RST)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .kick_i   (kick_w),
        .tick_i   (tick_w),
        .reload_i (reload_w),
        .running_o(running_w),
        .bark_o   (wdog_rst_o)
    );
endmodule

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wdog_rst_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_wr_cyc = 0;
    int bark_count = 0;
    int last_bark_cyc = 0;
    int wide_pulses = 0;
    logic prev_bark = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyed_wdog uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdog_rst_o(wdog_rst_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (wdog_rst_o) begin
            bark_count    <= bark_count + 1;
            last_bark_cyc <= cyc;
            if (prev_bark) wide_pulses <= wide_pulses + 1;
        end
        prev_bark <= wdog_rst_o;
    end

    function automatic int exp_period(input int code, input int rld);
        int dv;
        dv = (code >= 7) ? 256 : (4 << code);
        return (rld + 1) * dv;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk);
        #1;
        last_wr_cyc = cyc;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    // waits for the next request, returns cycles since the reference edge
    task automatic wait_bark(input int ref_cyc, input int limit, output int gap);
        int start_cnt;
        start_cnt = bark_count;
        gap = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            #1;
            if (bark_count != start_cnt) begin
                gap = last_bark_cyc - ref_cyc;
                break;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int v;
        int gap;
        int refc;
        int code;
        int rld;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h4, v); chk("R1 prescaler", v, 0);
        rd(4'h8, v); chk("R1 reload", v, 12'hFFF);
        rd(4'hC, v); chk("R1 status", v, 0);
        rd(4'h0, v); chk("R1 key", v, 0);
        chk("R1 reset out", int'(wdog_rst_o), 0);

        // R2 locked writes ignored
        wr(4'h4, 16'h0003);
        wr(4'h8, 16'h0010);
        rd(4'hC, v); chk("R2 status", v, 0);
        rd(4'h4, v); chk("R2 prescaler", v, 0);
        rd(4'h8, v); chk("R2 reload", v, 12'hFFF);

        // R3/R4 unlock and pending window
        wr(4'h0, 16'h5555);
        wr(4'h4, 16'h0002);
        for (int i = 0; i < 6; i++) begin
            rd(4'hC, v);
            chk("R4 prescaler pending", v & 1, ((cyc - last_wr_cyc) < 4) ? 1 : 0);
        end
        rd(4'h4, v); chk("R3 prescaler stored", v, 2);
        wr(4'h8, 16'h0005);
        for (int i = 0; i < 6; i++) begin
            rd(4'hC, v);
            chk("R4 reload pending", v, ((cyc - last_wr_cyc) < 4) ? 2 : 0);
        end
        rd(4'h8, v); chk("R3 reload stored", v, 5);
        wr(4'h0, 16'h1234);
        wr(4'h4, 16'h0005);
        rd(4'h4, v); chk("R3 relocked", v, 2);

        // R11 no request before start, even after refresh
        wr(4'h0, 16'hAAAA);
        repeat (300) @(negedge clk);
        chk("R11 no request idle", bark_count, 0);

        // R10 start while reload pending uses old value
        wr(4'h0, 16'h5555);
        wr(4'h8, 16'h0003);
        wr(4'h0, 16'hCCCC);
        refc = last_wr_cyc;
        wait_bark(refc, 2000, gap);
        chk("R10 R6 first period old reload", gap, exp_period(2, 5));
        refc = last_bark_cyc;
        wait_bark(refc, 2000, gap);
        chk("R7 next period new reload", gap, exp_period(2, 3));

        // R8 refresh restarts period
        repeat (20) @(negedge clk);
        wr(4'h0, 16'hAAAA);
        refc = last_wr_cyc;
        wait_bark(refc, 2000, gap);
        chk("R8 period from refresh", gap, exp_period(2, 3));

        // R9 stray keys do not stop the timer
        wr(4'h0, 16'hAAAA);
        refc = last_wr_cyc;
        wr(4'h0, 16'h0000);
        wr(4'h0, 16'h5555);
        wr(4'h0, 16'h1234);
        wait_bark(refc, 2000, gap);
        chk("R9 still running", gap, exp_period(2, 3));

        // R5 directed corner cases then random settings
        for (int k = 0; k < 12; k++) begin
            case (k)
                0: begin code = 0; rld = 0; end
                1: begin code = 6; rld = 1; end
                2: begin code = 7; rld = 1; end
                3: begin code = 0; rld = 12'hFFF; end
                default: begin
                    code = int'($urandom_range(0, 7));
                    rld  = int'($urandom_range(0, 15));
                end
            endcase
            wr(4'h0, 16'h5555);
            wr(4'h4, 16'(code));
            wr(4'h8, 16'(rld));
            repeat (6) @(negedge clk);
            rd(4'h4, v); chk("R3 code readback", v, code);
            wr(4'h0, 16'hAAAA);
            refc = last_wr_cyc;
            wait_bark(refc, 20000, gap);
            chk("R5 divided period", gap, exp_period(code, rld));
        end

        chk("R6 pulse width one cycle", wide_pulses, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule